// File: doc/BRIEF.md
# Received Flow-Character Detector and Interrupt

This block sits in the receive path of a serial channel. Every received character is compared against two programmable characters, the resume character and the halt character. A match drives a one-cycle request to the transmit flow engine and sets a sticky flag. The flags together form a maskable interrupt. The block also decides whether each received character goes on to the receive FIFO. A mode bit can keep matched flow characters out of the FIFO.

The comparators always run, whatever the flow-control mode bits hold. With flow gating off and the interrupt unmasked, the block therefore works as a general two-character detector. Software reads a detail status word to see which character fired. That read clears the sticky flags and so withdraws the interrupt status. A synchronous software reset and the asynchronous hardware reset both clear recognition state. A character that arrives during a software reset cycle is discarded.

Top module: `flowCharDetect`

## Requirements
- R1: After hardware reset, fifoPush, haltReq, resumeReq, isrBit and irqOut are 0, and detailStatus bits 1:0 are 0.
- R2: A character with rxValid=1 that equals resumeChar sets detailStatus bit 0 one cycle later. A character that equals haltChar sets bit 1. isrBit is the OR of bits 1:0.
- R3: Detection and the sticky flags work whatever the value of modeReg bits 3:2, including 00.
- R4: A received character gives fifoPush=1 and fifoData equal to the character one cycle later. The exception is a character that matches either register while modeReg bit 7 is 1: such a character gives fifoPush=0. Characters that match neither register are always pushed.
- R5: With modeReg bit 2 set, a halt match pulses haltReq for one cycle, one cycle after the character. A resume match that is not also a halt match pulses resumeReq in the same way. When one character matches both registers, only haltReq fires. With bit 2 clear, neither request pulses.
- R6: irqOut equals isrBit AND intMask bit 4.
- R7: statusRd=1 at a clock edge clears both sticky flags. A match at the same edge sets its own flag anyway, and the new match wins.
- R8: softRst=1 at a clock edge clears both flags. A character presented at that edge gives no push, no request and no flag.
- R9: detailStatus bit 2 follows the txGated input live. Bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| softRst | input | 1 | Synchronous software reset |
| rxValid | input | 1 | Received-character strobe |
| rxData | input | 8 | Received character |
| resumeChar | input | 8 | Resume (transmit-on) character |
| haltChar | input | 8 | Halt (transmit-off) character |
| modeReg | input | 8 | Mode: bit 7 drops matches, bit 2 enables flow gating |
| intMask | input | 8 | Interrupt mask; bit 4 enables this source |
| statusRd | input | 1 | Read strobe of the detail status word |
| txGated | input | 1 | Live transmitter-gated state from the flow engine |
| fifoPush | output | 1 | Push enable to the receive FIFO |
| fifoData | output | 8 | Character to the receive FIFO |
| haltReq | output | 1 | Halt request pulse to the flow engine |
| resumeReq | output | 1 | Resume request pulse to the flow engine |
| isrBit | output | 1 | Interrupt status bit for this source |
| irqOut | output | 1 | Masked interrupt request |
| detailStatus | output | 8 | Detail status word |

## Verification
fifoPush, fifoData, haltReq, resumeReq and the sticky flags each pass through one register, so they are due exactly one clock after the character. isrBit comes straight from the flags, so it is due at the same time. irqOut and detailStatus bit 2 follow their inputs in the same cycle. The bench drives inputs, waits for the next rising edge and samples one time unit later. At that point it updates its own model and compares every output, so each result is checked in the cycle it is due and never later.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef struct packed {
    logic load;
    logic setResume;
    logic setHalt;
    logic clrResume;
    logic clrHalt;
  } fcdStrobe_t;
endpackage

// File: rtl/fcd_datapath.sv
module fcd_datapath #(
  parameter int CHAR_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHAR_W-1:0]   rxData,
  input  logic [CHAR_W-1:0]   resumeChar,
  input  logic [CHAR_W-1:0]   haltChar,
  input  fcd_pkg::fcdStrobe_t stb,
  output logic                eqResume,
  output logic                eqHalt,
  output logic [CHAR_W-1:0]   dataQ,
  output logic                resumeFlag,
  output logic                haltFlag
);
  // Comparators run unconditionally; mode gating happens in control.
  assign eqResume = (rxData == resumeChar);
  assign eqHalt   = (rxData == haltChar);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ      <= '0;
      resumeFlag <= 1'b0;
      haltFlag   <= 1'b0;
    end else begin
      if (stb.load) dataQ <= rxData;
      if (stb.setResume)      resumeFlag <= 1'b1;
      else if (stb.clrResume) resumeFlag <= 1'b0;
      if (stb.setHalt)        haltFlag <= 1'b1;
      else if (stb.clrHalt)   haltFlag <= 1'b0;
    end
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setResume || stb.setHalt) |=> (resumeFlag || haltFlag));
endmodule

// File: rtl/fcd_control.sv
module fcd_control #(
  parameter int MODE_W   = 8,
  parameter int DROP_BIT = 7,
  parameter int GATE_BIT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                rxValid,
  input  logic                eqResume,
  input  logic                eqHalt,
  input  logic [MODE_W-1:0]   modeReg,
  input  logic                statusRd,
  output fcd_pkg::fcdStrobe_t stb,
  output logic                fifoPush,
  output logic                haltReq,
  output logic                resumeReq
);
  logic live, hitResume, hitHalt, anyHit, dropIt, gateOn;

  assign live      = rxValid && !softRst;
  assign hitResume = live && eqResume;
  assign hitHalt   = live && eqHalt;
  assign anyHit    = hitResume || hitHalt;
  assign dropIt    = anyHit && modeReg[DROP_BIT];
  assign gateOn    = modeReg[GATE_BIT];

  always_comb begin
    stb.load      = live;
    stb.setResume = hitResume;
    stb.setHalt   = hitHalt;
    stb.clrResume = softRst || statusRd;
    stb.clrHalt   = softRst || statusRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoPush  <= 1'b0;
      haltReq   <= 1'b0;
      resumeReq <= 1'b0;
    end else begin
      fifoPush  <= live && !dropIt;
      haltReq   <= gateOn && hitHalt;
      resumeReq <= gateOn && hitResume && !hitHalt;
    end
  end

  // R4
  drop_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && (eqResume || eqHalt) && modeReg[DROP_BIT]) |=> !fifoPush);
  // R5
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(haltReq && resumeReq));
endmodule

// File: rtl/flowCharDetect.sv
module flowCharDetect #(
  parameter int CHAR_W   = 8,
  parameter int MODE_W   = 8,
  parameter int MASK_W   = 8,
  parameter int DETAIL_W = 8,
  parameter int DROP_BIT = 7,
  parameter int GATE_BIT = 2,
  parameter int MASK_BIT = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                softRst,
  input  logic                rxValid,
  input  logic [CHAR_W-1:0]   rxData,
  input  logic [CHAR_W-1:0]   resumeChar,
  input  logic [CHAR_W-1:0]   haltChar,
  input  logic [MODE_W-1:0]   modeReg,
  input  logic [MASK_W-1:0]   intMask,
  input  logic                statusRd,
  input  logic                txGated,
  output logic                fifoPush,
  output logic [CHAR_W-1:0]   fifoData,
  output logic                haltReq,
  output logic                resumeReq,
  output logic                isrBit,
  output logic                irqOut,
  output logic [DETAIL_W-1:0] detailStatus
);
  localparam int PAD_W = DETAIL_W - 3;

  fcd_pkg::fcdStrobe_t stb;
  logic eqResume, eqHalt, resumeFlag, haltFlag;

  fcd_datapath #(.CHAR_W(CHAR_W)) uData (
    .clk(clk), .rstN(rstN), .rxData(rxData), .resumeChar(resumeChar),
    .haltChar(haltChar), .stb(stb), .eqResume(eqResume), .eqHalt(eqHalt),
    .dataQ(fifoData), .resumeFlag(resumeFlag), .haltFlag(haltFlag)
  );

  fcd_control #(.MODE_W(MODE_W), .DROP_BIT(DROP_BIT), .GATE_BIT(GATE_BIT)) uCtl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .rxValid(rxValid),
    .eqResume(eqResume), .eqHalt(eqHalt), .modeReg(modeReg),
    .statusRd(statusRd), .stb(stb), .fifoPush(fifoPush),
    .haltReq(haltReq), .resumeReq(resumeReq)
  );

  assign isrBit       = resumeFlag || haltFlag;
  assign irqOut       = isrBit && intMask[MASK_BIT];
  assign detailStatus = {{PAD_W{1'b0}}, txGated, haltFlag, resumeFlag};

  // R7
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !rxValid && !softRst) |=> !isrBit);
  // R8
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (!fifoPush && !haltReq && !resumeReq && !isrBit));
  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isrBit |-> !irqOut);
endmodule

// File: tb/tb_flowCharDetect.sv
module tb_flowCharDetect;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0, softRst = 0, rxValid = 0, statusRd = 0, txGated = 0;
  logic [7:0] rxData = 0, resumeChar = 8'h11, haltChar = 8'h13, modeReg = 0, intMask = 0;
  logic fifoPush, haltReq, resumeReq, isrBit, irqOut;
  logic [7:0] fifoData, detailStatus;

  int checks = 0, errors = 0;
  logic mResume = 0, mHalt = 0, ePush, eHalt, eResume;
  logic [7:0] eData = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flowCharDetect dut (.*);

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expDetail(input logic r, input logic h, input logic g);
    return {5'b0, g, h, r};
  endfunction

  task automatic checkAll();
    chk("R4 push", fifoPush, ePush);
    if (ePush) chk("R4 data", fifoData, eData);
    chk("R5 halt", haltReq, eHalt);
    chk("R5 resume", resumeReq, eResume);
    chk("R2 R9 detail", detailStatus, expDetail(mResume, mHalt, txGated));
    chk("R2 isr", isrBit, mResume | mHalt);
    chk("R6 irq", irqOut, (mResume | mHalt) & intMask[4]);
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic rd, input logic sr);
    logic hr, hh, live;
    rxValid = v; rxData = d; statusRd = rd; softRst = sr;
    live = v && !sr;
    hr = live && (d == resumeChar);
    hh = live && (d == haltChar);
    @(posedge clk); #1;
    ePush   = live && !((hr || hh) && modeReg[7]);
    if (live) eData = d;
    eHalt   = modeReg[2] && hh;
    eResume = modeReg[2] && hr && !hh;
    mResume = hr ? 1'b1 : ((sr || rd) ? 1'b0 : mResume);
    mHalt   = hh ? 1'b1 : ((sr || rd) ? 1'b0 : mHalt);
    checkAll();
    rxValid = 0; statusRd = 0; softRst = 0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    ePush = 0; eHalt = 0; eResume = 0;
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    checkAll();
    rstN = 1;
    @(negedge clk);
    // R3 detection with mode bits 3:2 = 00, mask on
    modeReg = 8'h00; intMask = 8'h10;
    step(1, 8'h11, 0, 0);
    step(1, 8'h41, 0, 0);     // R4 non-match pushed
    step(0, 8'h00, 1, 0);     // R7 read clears
    // R5 gating with bit 2, halt then resume
    modeReg = 8'h04;
    step(1, 8'h13, 0, 0);
    step(1, 8'h11, 0, 0);
    // R7 read and match same edge
    step(1, 8'h13, 1, 0);
    // R4 drop bit
    modeReg = 8'h84;
    step(1, 8'h11, 0, 0);
    step(1, 8'h55, 0, 0);
    // R8 soft reset with a matching character
    step(1, 8'h13, 0, 1);
    // R5 both registers equal: halt precedence
    resumeChar = 8'h13; modeReg = 8'h04;
    step(1, 8'h13, 0, 0);
    resumeChar = 8'h11;
    // R9 live gated flag, R6 mask off
    txGated = 1; intMask = 8'h00;
    step(0, 8'h00, 0, 0);
    txGated = 0; intMask = 8'h10;
    step(0, 8'h00, 1, 0);
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      d = (sel < 3) ? resumeChar : (sel < 6) ? haltChar : 8'($urandom);
      if ($urandom_range(0, 15) == 0) modeReg = 8'($urandom);
      if ($urandom_range(0, 15) == 0) intMask = 8'($urandom);
      if ($urandom_range(0, 31) == 0) haltChar = ($urandom_range(0, 3) == 0) ? resumeChar : 8'h13;
      txGated = 1'($urandom);
      step(1'($urandom_range(0, 3) != 0), d, $urandom_range(0, 5) == 0, $urandom_range(0, 40) == 0);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule